// File: doc/BRIEF.md
# I/O interrupt redirection unit

This block sits between a bank of external interrupt lines and the interrupt delivery fabric. Each input line owns a 64-bit redirection entry, which software programs to give the vector, delivery mode, destination, destination mode, polarity and trigger mode. The block tracks a pending bit per line. Each pending, unmasked line turns into a delivery message that carries the fields of its entry.

Software reaches the block through two 32-bit locations. Offset 0x00 holds a select value. Offset 0x10 is a data window onto whichever internal register the select value names. Each entry is split into a low and a high 32-bit half, and each half has its own select value.

Messages leave the block on a valid/ready port, one message per handshake. The line with the lowest number is offered first. Edge-triggered lines are consumed by delivery. Level-triggered lines stay pending for as long as the pin is high.

Top module: `ioredir_unit`

## Requirements
- R1: After reset the select register and the ID read 0. Every entry reads 0x00010000 in its low half and 0 in its high half, so the mask bit is set. No pending state remains and `msg_valid` is low.
- R2: A write to offset 0x00 stores bits 7:0 as the select value, and a read of offset 0x00 returns that value in bits 7:0. Writes to offsets other than 0x00 and 0x10 are ignored, and reads of those offsets return 0.
- R3: Through the window, select 0 holds the ID in bits 31:24 and reads the other bits as 0. Select 1 reads 0x00170011: version 0x11, and the entry count minus one in bits 23:16. Select 2 reads 0, and writes to it are ignored.
- R4: Entry n is reached at select 0x10+2n for its low half and at 0x11+2n for its high half. A window write replaces only the selected half. A select value past the last entry reads 0.
- R5: A message carries the following fields of its pin's entry: vector from low bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, polarity from bit 13, trigger mode from bit 15, and destination from high-half bits 31:24. It also carries the pin number.
- R6: A pin whose bit 15 is 1 is level-triggered. Its pending bit copies the pin level on each clock. It stays pending after a handshake and is offered again only after a new service event. If the pin falls before the handshake, the offer is withdrawn.
- R7: A pin whose bit 15 is 0 is edge-triggered. A rising input sets its pending bit, and the handshake that delivers it clears the bit. A rising input in the same cycle as that handshake keeps the bit set and re-arms the message.
- R8: A rising edge on any pin, or a write to any entry half, is a service event. A service event arms one message for every pending pin.
- R9: A pin whose bit 16 is set is never offered. It still collects pending state, and a write that clears the mask delivers that pending state.
- R10: Among the armed, pending, unmasked pins, the lowest-numbered one is offered. The offer holds while `msg_ready` is low. A pin change is seen one clock later on the message port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 24 | Interrupt input lines, active high |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 8 | Register offset |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_pin | output | 5 | Source pin number |
| msg_vector | output | 8 | Vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | Destination mode |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode, 1 = level |
| msg_dest | output | 8 | Destination |

## Verification
Two functions can land on the same pin in the same cycle: delivery clearing an edge pin's pending bit, and a new rising edge on that pin setting it again. The bench provokes this by raising the pin again in the same cycle that it completes the handshake. It then expects the same pin to be offered on the next cycle, both in a directed check and in the clock-by-clock reference model. Entry writes that arrive while a level pin is still pending are judged the same way: the model expects the re-armed offer one clock after the window write.

// File: rtl/ioredir_unit.sv
module ioredir_unit #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                acc_wr,
  input  logic [7:0]          acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [PIN_W-1:0]    msg_pin,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dmode,
  output logic                msg_destmode,
  output logic                msg_polarity,
  output logic                msg_trigger,
  output logic [7:0]          msg_dest
);
  localparam logic [8:0] TBL_END = 9'(16 + 2 * NUM_PINS);

  logic [31:0] lo_q [NUM_PINS];
  logic [31:0] hi_q [NUM_PINS];
  logic [7:0]  sel_q, id_q;
  logic [NUM_PINS-1:0] pend_q, req_q, prev_q;
  logic [NUM_PINS-1:0] pend_nx, req_nx, clr, trig, mask, rise, eff;
  logic [PIN_W-1:0] pick;

  wire       win_wr   = acc_wr && acc_addr == 8'h10;
  wire       in_tbl   = sel_q >= 8'h10 && {1'b0, sel_q} < TBL_END;
  wire [7:0] tbl_off  = sel_q - 8'h10;
  wire [PIN_W-1:0] ent_idx = tbl_off[PIN_W:1];
  wire       ent_half = tbl_off[0];
  wire       ent_wr   = win_wr && in_tbl;
  wire       hs       = msg_valid && msg_ready;

  assign rise = irq_in & ~prev_q;
  wire svc = (|rise) || ent_wr;

  always_comb begin
    clr = '0;
    if (hs) clr[msg_pin] = 1'b1;
    for (int i = 0; i < NUM_PINS; i++) begin
      trig[i] = lo_q[i][15];
      mask[i] = lo_q[i][16];
      pend_nx[i] = trig[i] ? irq_in[i] : ((pend_q[i] & ~clr[i]) | rise[i]);
    end
  end

  assign req_nx = (req_q & ~clr) | (svc ? pend_nx : '0);
  assign eff = req_q & pend_q & ~mask;

  always_comb begin
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (eff[i]) pick = PIN_W'(i);
  end

  assign msg_valid    = |eff;
  assign msg_pin      = pick;
  assign msg_vector   = lo_q[pick][7:0];
  assign msg_dmode    = lo_q[pick][10:8];
  assign msg_destmode = lo_q[pick][11];
  assign msg_polarity = lo_q[pick][13];
  assign msg_trigger  = lo_q[pick][15];
  assign msg_dest     = hi_q[pick][31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      pend_q <= '0;
      req_q  <= '0;
      prev_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        lo_q[i] <= 32'h0001_0000;
        hi_q[i] <= '0;
      end
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_nx;
      req_q  <= req_nx;
      if (acc_wr && acc_addr == 8'h00) sel_q <= acc_wdata[7:0];
      if (win_wr && sel_q == 8'h00) id_q <= acc_wdata[31:24];
      if (ent_wr) begin
        if (ent_half) hi_q[ent_idx] <= acc_wdata;
        else          lo_q[ent_idx] <= acc_wdata;
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_addr == 8'h00) acc_rdata = {24'h0, sel_q};
    else if (acc_addr == 8'h10) begin
      if (sel_q == 8'h00)      acc_rdata = {id_q, 24'h0};
      else if (sel_q == 8'h01) acc_rdata = {8'h0, 8'(NUM_PINS - 1), 8'h0, VERSION};
      else if (in_tbl)         acc_rdata = ent_half ? hi_q[ent_idx] : lo_q[ent_idx];
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !msg_valid);

  assert_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !lo_q[msg_pin][16]);

  assert_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (eff & ((NUM_PINS'(1) << msg_pin) - NUM_PINS'(1))) == '0);

  assert_level_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_trigger) |-> ((($past(irq_in) >> msg_pin) & NUM_PINS'(1)) != '0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
    assert_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr && !ent_half && ent_idx == PIN_W'(g)) |=> $stable(hi_q[g]));
    assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && msg_pin == PIN_W'(g) && !trig[g] && !rise[g]) |=> !pend_q[g]);
  end
endmodule

// File: tb/ioredir_unit_test.sv
module ioredir_unit_test;
  localparam int CLK_NS = 10;
  localparam int N = 24;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic acc_wr = 0;
  logic [7:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic msg_valid, msg_ready = 0;
  logic [4:0] msg_pin;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dmode;
  logic msg_destmode, msg_polarity, msg_trigger;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  ioredir_unit uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [7:0] m_sel;
  logic [N-1:0] m_pend, m_req, m_prev;

  function automatic int m_pick();
    for (int i = 0; i < N; i++)
      if (m_req[i] && m_pend[i] && !m_lo[i][16]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_pend = 0; m_req = 0; m_prev = 0;
      for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 0; end
    end else begin
      int hp; bit hs, anyr, ew; logic [N-1:0] np;
      hp = m_pick(); hs = (hp >= 0) && msg_ready; anyr = 0; ew = 0;
      for (int i = 0; i < N; i++) begin
        bit r; r = irq_in[i] && !m_prev[i];
        if (r) anyr = 1;
        if (m_lo[i][15]) np[i] = irq_in[i];
        else np[i] = (m_pend[i] && !(hs && hp == i)) || r;
      end
      if (acc_wr && acc_addr == 8'h00) m_sel = acc_wdata[7:0];
      else if (acc_wr && acc_addr == 8'h10 && m_sel >= 16 && int'(m_sel) < 16 + 2*N) begin
        ew = 1;
        if (m_sel[0]) m_hi[(m_sel-16)/2] = acc_wdata; else m_lo[(m_sel-16)/2] = acc_wdata;
      end
      for (int i = 0; i < N; i++) begin
        if (hs && hp == i) m_req[i] = 0;
        if ((anyr || ew) && np[i]) m_req[i] = 1;
      end
      m_pend = np; m_prev = irq_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // clock-by-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    int p; p = m_pick();
    chk("R10 valid", {31'h0, msg_valid}, {31'h0, p >= 0});
    if (p >= 0) begin
      chk("R10 pin", {27'h0, msg_pin}, 32'(p));
      chk("R5 fields", {msg_vector, 5'h0, msg_dmode, 6'h0, msg_destmode, msg_polarity, msg_trigger, msg_dest},
          {m_lo[p][7:0], 5'h0, m_lo[p][10:8], 6'h0, m_lo[p][11], m_lo[p][13], m_lo[p][15], m_hi[p][31:24]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    acc_wr = 1; acc_addr = a; acc_wdata = d; step(); acc_wr = 0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    acc_addr = a; #1; d = acc_rdata;
  endtask
  task automatic rdsel(logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s}); rd(8'h10, d);
  endtask
  task automatic went(int pin, bit half, logic [31:0] v);
    wr(8'h00, 32'(16 + 2*pin + half)); wr(8'h10, v);
  endtask
  task automatic hshake(); msg_ready = 1; step(); msg_ready = 0; endtask
  task automatic expv(string tag, bit v, int pin);
    chk(tag, {31'h0, msg_valid}, {31'h0, v});
    if (v) chk(tag, {27'h0, msg_pin}, 32'(pin));
  endtask

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1; step();
    // reset state
    rd(8'h00, d); chk("R1 select", d, 0);
    chk("R1 no message", {31'h0, msg_valid}, 0);
    rdsel(8'h00, d); chk("R1 id", d, 0);
    rdsel(8'h10, d); chk("R1 entry lo", d, 32'h0001_0000);
    rdsel(8'h2f, d); chk("R1 entry hi", d, 0);
    rdsel(8'h01, d); chk("R3 version", d, 32'h0017_0011);
    // id, select 2, stray offsets
    wr(8'h00, 0); wr(8'h10, 32'hAB12_3456); rd(8'h10, d); chk("R3 id", d, 32'hAB00_0000);
    wr(8'h00, 2); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 sel2", d, 0);
    wr(8'h20, 32'h0000_0005); rd(8'h20, d); chk("R2 stray read", d, 0);
    rd(8'h00, d); chk("R2 select kept", d, 2);
    rdsel(8'h40, d); chk("R4 past table", d, 0);
    // entry halves, pin 3 edge
    went(3, 1, 32'h5A00_0000);
    rdsel(8'h16, d); chk("R4 lo untouched", d, 32'h0001_0000);
    went(3, 0, 32'h0000_0B42);
    rdsel(8'h17, d); chk("R4 hi kept", d, 32'h5A00_0000);
    rdsel(8'h16, d); chk("R4 lo written", d, 32'h0000_0B42);
    irq_in[3] = 1; step();
    expv("R7 edge set", 1, 3);
    chk("R5 vector", {24'h0, msg_vector}, 32'h42);
    chk("R5 dest", {24'h0, msg_dest}, 32'h5A);
    chk("R5 dmode/destmode/trig", {29'h0, msg_dmode}, 3);
    chk("R5 destmode", {31'h0, msg_destmode}, 1);
    step(); step(); expv("R10 hold without ready", 1, 3);
    hshake(); expv("R7 cleared by delivery", 0, 0);
    irq_in[3] = 0; step();
    // level pin 5
    went(5, 0, 32'h0000_8021);
    irq_in[5] = 1; step(); expv("R6 level offered", 1, 5);
    chk("R5 trigger", {31'h0, msg_trigger}, 1);
    hshake(); expv("R6 no repeat", 0, 0);
    went(5, 0, 32'h0000_8021); expv("R8 entry write re-arms", 1, 5);
    hshake(); expv("R6 after second delivery", 0, 0);
    irq_in[5] = 0; step(); irq_in[5] = 1; step(); expv("R6 new assertion", 1, 5);
    irq_in[5] = 0; step(); expv("R6 withdrawn", 0, 0);
    irq_in[5] = 1; step(); hshake(); expv("R6 delivered", 0, 0);
    // service event arms the held level pin
    went(2, 0, 32'h0000_0012);
    hshake(); expv("R6 quiet", 0, 0);
    irq_in[2] = 1; step(); expv("R8 edge first", 1, 2);
    hshake(); expv("R8 level re-armed", 1, 5);
    hshake(); expv("R8 drained", 0, 0);
    irq_in[2] = 0; irq_in[5] = 0; step();
    // mask
    went(7, 0, 32'h0001_0030);
    irq_in[7] = 1; step(); expv("R9 masked", 0, 0);
    irq_in[7] = 0; step(); expv("R9 still masked", 0, 0);
    went(7, 0, 32'h0000_0030); expv("R9 unmask delivers", 1, 7);
    chk("R9 vector", {24'h0, msg_vector}, 32'h30);
    hshake(); expv("R9 done", 0, 0);
    // priority
    went(9, 0, 32'h0000_0019);
    irq_in[9] = 1; irq_in[2] = 1; step(); expv("R10 lowest first", 1, 2);
    hshake(); expv("R10 next", 1, 9);
    hshake(); expv("R10 empty", 0, 0);
    irq_in[9] = 0; irq_in[2] = 0; step();
    // rise coincides with handshake
    irq_in[3] = 1; step(); expv("R7 offered", 1, 3);
    irq_in[3] = 0; step();
    irq_in[3] = 1; msg_ready = 1; step(); msg_ready = 0;
    expv("R7 rise with handshake re-arms", 1, 3);
    hshake(); expv("R7 final clear", 0, 0);
    irq_in = '0; step(); step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule